// File: doc/BRIEF.md
# Periodic Interrupt and Flag Controller

This block sits beside a real-time clock core. It produces a periodic event and a square wave from a 32.768 kHz clock-enable pulse, and it gathers three interrupt causes into one request line. The three causes are the periodic event, an alarm match and the end of a time update. A single 4-bit rate code sets both the periodic event rate and the square-wave frequency. A free-running 15-bit counter advances on each enable pulse. The chosen power-of-two slice of that counter gives both outputs.

Software programs the block with one configuration write. That write holds the rate code and an enable bit for each cause. Software can poll the flag register or wait for the active-low request. A flag is recorded whether or not its enable is set. A read captures the flags and holds them stable for as long as the read strobe is high. The captured flags clear when the read ends. Events that arrive while a read is in progress are kept and become visible once the read has ended.

Top module: `pirq_ctrl`

## Requirements
- R1: Rate code 0 stops the periodic event and holds the square wave low.
- R2: For a rate code c from 3 to 15, periodic flag events occur every 2^(c-1) clock-enable pulses, also when the enable pulses are spaced apart.
- R3: Rate codes 1 and 2 give the same periods as codes 8 and 9, that is 2^7 and 2^8 enable pulses.
- R4: The square wave has the period of the periodic event and a 50% duty cycle. Its low-to-high edge comes half a period before each periodic event.
- R5: Each cause sets its flag whether or not its enable is set. The flag bits of the flag register are: bit 2 periodic, bit 1 alarm, bit 0 update. Configuration word bits: [3:0] rate code, bit 4 periodic enable, bit 5 alarm enable, bit 6 update enable.
- R6: Flag bit 3 and the request output `irq_n` (low) are active when at least one flag has its enable set. Writing an enable for a flag that is already set raises the request.
- R7: While `rd_flags` stays high, the flag register value does not change.
- R8: When a read ends, the flags it captured clear. The request releases one clock after `rd_flags` falls, and not before.
- R9: An event that occurs during a read is not lost. It appears in the flag register after the read ends.
- R10: After reset the flags read 0, `irq_n` is high and `sqw` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick32k | input | 1 | 32.768 kHz clock-enable pulse |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_data | input | 7 | Rate code [3:0] and the periodic, alarm and update enables [6:4] |
| alarm_hit | input | 1 | One-cycle alarm match pulse |
| update_done | input | 1 | One-cycle end-of-update pulse |
| rd_flags | input | 1 | Flag register read strobe, high for the length of the read |
| flags | output | 4 | Combined request bit [3], periodic [2], alarm [1], update [0] |
| irq_n | output | 1 | Active-low interrupt request |
| sqw | output | 1 | Square-wave output |

## Verification
The bench sweeps every rate code and measures the interval between successive periodic flags. This separates the exponent mapping of each code and shows that codes 1 and 2 alias codes 8 and 9. A second run with an enable pulse only every third clock shows that the count follows the enable pulses and not the system clock. For the low codes, the square-wave high time and period are measured; these catch a wrong counter bit or a wrong duty cycle. The read sequences place an event inside a held read and change the enables with flags already set. These sequences tell a live flag view apart from a captured one, and an early request release apart from a correct one.

// File: rtl/pirq_ctrl.sv
module pirq_ctrl #(
  parameter int DIV_W  = 15,
  parameter int RATE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick32k,
  input  logic              cfg_we,
  input  logic [RATE_W+2:0] cfg_data,
  input  logic              alarm_hit,
  input  logic              update_done,
  input  logic              rd_flags,
  output logic [3:0]        flags,
  output logic              irq_n,
  output logic              sqw
);
  localparam int EXP_W = $clog2(DIV_W + 1);

  logic [DIV_W-1:0]  cnt;
  logic [RATE_W-1:0] rate_q;
  logic [2:0]        en_q, pend, snap, vis, ev;
  logic              in_rd, start, per_hit;
  logic [EXP_W-1:0]  expo;
  logic [DIV_W-1:0]  mask, top;

  always_comb begin
    case (rate_q)
      RATE_W'(0): expo = '0;
      RATE_W'(1): expo = EXP_W'(7);
      RATE_W'(2): expo = EXP_W'(8);
      default:    expo = EXP_W'(rate_q) - EXP_W'(1);
    endcase
  end

  assign mask    = (DIV_W'(1) << expo) - DIV_W'(1);
  assign top     = mask ^ (mask >> 1);
  assign per_hit = tick32k && (expo != '0) && ((cnt & mask) == mask);
  assign sqw     = (expo != '0) && ((cnt & top) != '0);

  assign ev    = {per_hit, alarm_hit, update_done};
  assign start = rd_flags && !in_rd;
  assign vis   = in_rd ? snap : pend;
  assign flags = {|(vis & en_q), vis};
  assign irq_n = ~|((pend | snap) & en_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      rate_q <= '0;
      en_q   <= '0;
      pend   <= '0;
      snap   <= '0;
      in_rd  <= 1'b0;
    end else begin
      cnt   <= cnt + DIV_W'(tick32k);
      in_rd <= rd_flags;
      pend  <= (start ? 3'b000 : pend) | ev;
      snap  <= start ? pend : (rd_flags ? snap : 3'b000);
      if (cfg_we) begin
        rate_q <= cfg_data[RATE_W-1:0];
        en_q   <= {cfg_data[RATE_W], cfg_data[RATE_W+1], cfg_data[RATE_W+2]};
      end
    end
  end
endmodule

// File: rtl/pirq_ctrl_chk.sv
module pirq_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rd_flags,
  input logic       alarm_hit,
  input logic       update_done,
  input logic       per_hit,
  input logic       cfg_we,
  input logic [3:0] flags,
  input logic       irq_n,
  input logic       sqw,
  input logic [3:0] rate_q,
  input logic [2:0] pend
);
  AST_IDLE_SQW_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    rate_q == 4'd0 |-> !sqw); // R1

  AST_ALARM_RECORDED: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_hit && !rd_flags |=> flags[1]); // R5

  AST_REQ_MATCHES_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_flags && !$past(rd_flags) |-> irq_n == !flags[3]); // R6

  AST_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_flags && $past(rd_flags) && !$past(cfg_we) |-> $stable(flags)); // R7

  AST_CLEAR_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rd_flags) && !rd_flags && pend == 3'b000 && !alarm_hit
      && !update_done && !per_hit |=> flags == 4'b0000 && irq_n); // R8

  AST_EVENT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    rd_flags && update_done |=> pend[0]); // R9
endmodule

bind pirq_ctrl pirq_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rd_flags(rd_flags), .alarm_hit(alarm_hit),
  .update_done(update_done), .per_hit(per_hit), .cfg_we(cfg_we),
  .flags(flags), .irq_n(irq_n), .sqw(sqw), .rate_q(rate_q), .pend(pend)
);

// File: tb/pirq_ctrl_test.sv
module pirq_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick32k = 1'b0;
  logic       cfg_we = 1'b0;
  logic [6:0] cfg_data = '0;
  logic       alarm_hit = 1'b0;
  logic       update_done = 1'b0;
  logic       rd_flags = 1'b0;
  logic [3:0] flags;
  logic       irq_n;
  logic       sqw;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int tgap = 1;
  int tph = 0;
  int per_of[16];

  always #2.5 clk = ~clk;

  pirq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .tick32k(tick32k), .cfg_we(cfg_we),
    .cfg_data(cfg_data), .alarm_hit(alarm_hit), .update_done(update_done),
    .rd_flags(rd_flags), .flags(flags), .irq_n(irq_n), .sqw(sqw)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    tph = (tph + 1) % tgap;
    tick32k = (tph == 0);
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] d);
    cfg_we = 1'b1;
    cfg_data = d;
    @(negedge clk);
    cfg_we = 1'b0;
    @(negedge clk);
  endtask

  task automatic rd(input int n);
    rd_flags = 1'b1;
    repeat (n) @(negedge clk);
    rd_flags = 1'b0;
    @(negedge clk);
  endtask

  task automatic wait_per();
    while (!flags[2]) @(negedge clk);
  endtask

  function automatic int expo_of(input int c);
    if (c == 1) return 7;
    if (c == 2) return 8;
    return c - 1;
  endfunction

  task automatic measure(input int code, output int period);
    int t0;
    wr(7'(code));
    rd(1);
    wait_per();
    rd(1);
    wait_per();
    t0 = cyc;
    chk("R5 flag without enable, no request", int'(irq_n), 1);
    rd(1);
    wait_per();
    period = cyc - t0;
  endtask

  initial begin
    #(5.0 * 195000);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int p, hi, lo, sq_seen;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 flags", int'(flags), 0);
    chk("R10 irq_n", int'(irq_n), 1);
    chk("R10 sqw", int'(sqw), 0);

    // R1: rate code 0
    wr(7'd0);
    sq_seen = 0;
    for (int i = 0; i < 400; i++) begin
      if (sqw || flags[2]) sq_seen++;
      @(negedge clk);
    end
    chk("R1 no periodic/sqw activity", sq_seen, 0);

    // R2, R3: sweep all nonzero codes
    for (int c = 1; c < 16; c++) begin
      measure(c, p);
      per_of[c] = p;
      chk(c > 2 ? "R2 period" : "R3 period", p, 1 << expo_of(c));
    end
    chk("R3 code1 equals code8", per_of[1], per_of[8]);
    chk("R3 code2 equals code9", per_of[2], per_of[9]);

    // R4: square wave shape
    for (int c = 3; c < 12; c++) begin
      wr(7'(c));
      while (sqw) @(negedge clk);
      while (!sqw) @(negedge clk);
      hi = 0;
      lo = 0;
      while (sqw) begin hi++; @(negedge clk); end
      while (!sqw) begin lo++; @(negedge clk); end
      chk("R4 sqw high time", hi, 1 << (expo_of(c) - 1));
      chk("R4 sqw period", hi + lo, 1 << expo_of(c));
    end

    // R2 with spaced enable pulses
    tgap = 3;
    measure(4, p);
    chk("R2 period with spaced ticks", p, 8 * 3);
    tgap = 1;

    // R6: alarm enabled, update not enabled
    wr(7'b010_0000);
    rd(1);
    chk("R8 cleared before test", int'(flags), 0);
    alarm_hit = 1'b1;
    @(negedge clk);
    alarm_hit = 1'b0;
    chk("R6 alarm flags", int'(flags), 4'b1010);
    chk("R6 irq_n asserted", int'(irq_n), 0);
    update_done = 1'b1;
    @(negedge clk);
    update_done = 1'b0;
    chk("R5 update flag without enable", int'(flags), 4'b1011);

    // R7, R8, R9: held read with an event inside it
    rd_flags = 1'b1;
    @(negedge clk);
    chk("R7 captured value", int'(flags), 4'b1011);
    alarm_hit = 1'b0;
    update_done = 1'b1;
    @(negedge clk);
    update_done = 1'b0;
    chk("R7 stable during read", int'(flags), 4'b1011);
    @(negedge clk);
    chk("R7 stable later in read", int'(flags), 4'b1011);
    rd_flags = 1'b0;
    chk("R8 request held until read ends", int'(irq_n), 0);
    @(negedge clk);
    chk("R9 update kept, alarm cleared", int'(flags), 4'b0001);
    chk("R8 request released", int'(irq_n), 1);

    // R6: enabling an already-set flag raises the request
    wr(7'b100_0000);
    chk("R6 enable raises request", int'(irq_n), 0);
    chk("R6 combined bit", int'(flags), 4'b1001);
    rd(1);
    chk("R8 clear after read", int'(flags), 0);
    chk("R8 irq released after read", int'(irq_n), 1);

    // R6: periodic source with enable
    wr(7'b001_0011);
    wait_per();
    chk("R6 periodic request", int'(irq_n), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule